// File: doc/BRIEF.md
# Accumulator Fetch/Execute Core

This block is a small multicycle processor core for an 18-bit machine with a single accumulator. Each instruction word holds a 2-bit opcode in its top bits and a 16-bit direct address below it. The core steps a program counter through a synchronous word memory. It decodes the opcode into one of four actions: write the accumulator to memory, add a memory word to the accumulator, branch when the accumulator is negative, or hand the word to an external operate unit.

The operate unit sees a request with the 16-bit action field and the current accumulator. It answers with a one-cycle done strobe, a new accumulator value and an optional halt flag. A halt parks the core in an idle state until the start input is pulsed again. Execution then resumes at the word after the halting instruction. Arithmetic is ones'-complement with end-around carry, and bit 17 is the sign.

Top module: `acc_core`

## Requirements
- R1: During and right after reset the core is idle: `running`=0, `pc_q`=0, `acc_q`=0, `mem_we`=0, `opr_req`=0.
- R2: A one-cycle `start` pulse while idle makes `running` rise on the next edge, and fetching begins at `pc_q`. A `start` pulse while running has no effect. While idle without `start`, `running` and `pc_q` stay unchanged.
- R3: In the fetch cycle `mem_addr` equals `pc_q`. The word returned one cycle later is decoded, and `pc_q` then increments by one, wrapping from 0xFFFF to 0x0000.
- R4: Opcode 00 (bits 17:16) stores. In the fourth cycle of the instruction, `mem_we`=1, `mem_addr` is bits 15:0 of the word and `mem_wdata` equals `acc_q`. `mem_we` is never high at any other time.
- R5: Opcode 01 adds the word at the address in bits 15:0 to the accumulator. The sum is ones'-complement: the carry out of bit 17 is added back at bit 0. The result is visible after the fourth cycle.
- R6: Opcode 10 takes three cycles. If `acc_q[17]`=1, `pc_q` becomes bits 15:0 of the word; otherwise it keeps the incremented value.
- R7: Opcode 11 holds `opr_req` high with `opr_field` equal to bits 15:0 of the word until `opr_done`. On the done cycle `acc_q` takes `opr_acc_in`, and the next fetch follows.
- R8: If `opr_halt` is high with `opr_done`, the core goes idle instead of fetching. It stays idle until the next `start`, with `pc_q` pointing past the operate word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Run pulse, honoured only while idle |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 18 | Memory read data, one cycle after address |
| opr_req | output | 1 | Operate request to the operate unit |
| opr_field | output | 16 | Action field of the operate word |
| opr_done | input | 1 | Operate unit finished (one-cycle strobe) |
| opr_acc_in | input | 18 | New accumulator value from the operate unit |
| opr_halt | input | 1 | Operate unit requests halt, with `opr_done` |
| acc_q | output | 18 | Accumulator |
| pc_q | output | 16 | Program counter |
| running | output | 1 | High while the fetch loop is active |

## Verification
The properties take for granted that the memory returns the addressed word exactly one cycle after it samples the address. They also assume `opr_done` is raised only while `opr_req` is high and for a single cycle, and that `opr_halt` matters only alongside that strobe. The bench's operate responder only answers an open request, waits a number of cycles taken from the action field, and drops done on the next cycle. Its memory model has a fixed one-cycle read latency. The start pulses are driven both while idle and in the middle of a run, so that the ignored case is covered without breaking these assumptions.

// File: rtl/acc_core_pkg.sv
// Shared types for the accumulator core: sequencer states and primary opcodes.
// Assumes the opcode field is exactly two bits wide.
package acc_core_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM
    } core_state_t;

    typedef enum logic [1:0] {
        OP_STORE = 2'b00,
        OP_ADD   = 2'b01,
        OP_BRNEG = 2'b10,
        OP_OPER  = 2'b11
    } opcode_t;
endpackage

// File: rtl/acc_core_ocadd.sv
// Ones'-complement adder: the carry out of the top bit wraps into bit 0.
// Assumes W >= 2; the wrap cannot overflow a second time.
module acc_core_ocadd #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    // raw binary sum with carry out
    assign raw = {1'b0, a} + {1'b0, b};
    // end-around carry back into the low bit
    assign sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/acc_core_ctrl.sv
// Sequencer for the accumulator core. Walks idle, fetch, decode, execute and
// the extra memory cycle used by store and add. Assumes opr_done is a single
// cycle strobe given only while the operate request is open.
module acc_core_ctrl
    import acc_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  opcode_t     op,
    input  logic        opr_done,
    input  logic        opr_halt,
    output core_state_t state
);
    core_state_t state_nx;

    // next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC: begin
                case (op)
                    OP_STORE, OP_ADD: state_nx = ST_MEM;
                    OP_BRNEG:         state_nx = ST_FETCH;
                    OP_OPER: begin
                        if (opr_done) state_nx = opr_halt ? ST_IDLE : ST_FETCH;
                    end
                    default:          state_nx = ST_FETCH;
                endcase
            end
            ST_MEM:    state_nx = ST_FETCH;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/acc_core.sv
// Top of the accumulator core. Holds the program counter, address register,
// buffer register, opcode register and accumulator, and drives the memory and
// operate-unit ports. Assumes a memory with one cycle of read latency and a
// word of exactly two opcode bits above the address field.
module acc_core
    import acc_core_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              opr_req,
    output logic [ADDR_W-1:0] opr_field,
    input  logic              opr_done,
    input  logic [WORD_W-1:0] opr_acc_in,
    input  logic              opr_halt,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic              running
);
    localparam int SIGN_B = WORD_W - 1;

    core_state_t       state;
    opcode_t           ir;
    logic [ADDR_W-1:0] pc, mar;
    logic [WORD_W-1:0] mbr, acc, add_sum;

    acc_core_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (ir),
        .opr_done (opr_done),
        .opr_halt (opr_halt),
        .state    (state)
    );

    acc_core_ocadd #(.W(WORD_W)) u_add (
        .a   (acc),
        .b   (mem_rdata),
        .sum (add_sum)
    );

    // program counter: step after decode, load on a taken negative branch
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (state == ST_DECODE)
            pc <= pc + 1'b1;
        else if (state == ST_EXEC && ir == OP_BRNEG && acc[SIGN_B])
            pc <= mar;
    end

    // address and opcode registers: take PC at fetch, word fields at decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            ir  <= OP_STORE;
        end else if (state == ST_FETCH) begin
            mar <= pc;
        end else if (state == ST_DECODE) begin
            mar <= mem_rdata[ADDR_W-1:0];
            ir  <= opcode_t'(mem_rdata[WORD_W-1:ADDR_W]);
        end
    end

    // buffer register: instruction word, store data, or fetched operand
    always_ff @(posedge clk) begin
        if (!rst_n)
            mbr <= '0;
        else if (state == ST_DECODE)
            mbr <= mem_rdata;
        else if (state == ST_EXEC && ir == OP_STORE)
            mbr <= acc;
        else if (state == ST_MEM && ir == OP_ADD)
            mbr <= mem_rdata;
    end

    // accumulator: add result or operate-unit result
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (state == ST_MEM && ir == OP_ADD)
            acc <= add_sum;
        else if (state == ST_EXEC && ir == OP_OPER && opr_done)
            acc <= opr_acc_in;
    end

    // port drive: PC goes straight to memory in fetch to save a cycle
    always_comb begin
        mem_addr  = (state == ST_FETCH) ? pc : mar;
        mem_we    = (state == ST_MEM) && (ir == OP_STORE);
        mem_wdata = mbr;
        opr_req   = (state == ST_EXEC) && (ir == OP_OPER);
        opr_field = mbr[ADDR_W-1:0];
        acc_q     = acc;
        pc_q      = pc;
        running   = (state != ST_IDLE);
    end
endmodule

// File: rtl/acc_core_checks.sv
// Port-level properties for the accumulator core, attached with bind.
// Assumes opr_done only comes while opr_req is high.
module acc_core_checks #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              opr_req,
    input logic [ADDR_W-1:0] opr_field,
    input logic              opr_done,
    input logic              opr_halt,
    input logic [WORD_W-1:0] acc_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic              running
);
    // idle without start stays idle with a frozen PC
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> (!running && $stable(pc_q)));

    // writes happen only while running, carrying the accumulator
    assert_write_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> running);
    assert_write_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc_q));

    // an open operate request persists with a steady field
    assert_req_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opr_req && !opr_done) |=> (opr_req && $stable(opr_field)));

    // no memory write while an operate request is open
    assert_req_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(opr_req && mem_we));

    // halting operate completion leaves the core idle
    assert_halt_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opr_req && opr_done && opr_halt) |=> !running);
endmodule

bind acc_core acc_core_checks #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .opr_req   (opr_req),
    .opr_field (opr_field),
    .opr_done  (opr_done),
    .opr_halt  (opr_halt),
    .acc_q     (acc_q),
    .pc_q      (pc_q),
    .running   (running)
);

// File: tb/acc_core_test.sv
// Bench: behavioural memory, operate responder and per-cycle reference model.
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] mem_addr;
    logic [17:0] mem_wdata;
    logic        mem_we;
    logic [17:0] mem_rdata;
    logic        opr_req;
    logic [15:0] opr_field;
    logic        opr_done;
    logic [17:0] opr_acc_in;
    logic        opr_halt;
    logic [17:0] acc_q;
    logic [15:0] pc_q;
    logic        running;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .opr_req(opr_req), .opr_field(opr_field),
        .opr_done(opr_done), .opr_acc_in(opr_acc_in), .opr_halt(opr_halt),
        .acc_q(acc_q), .pc_q(pc_q), .running(running)
    );

    // memory model: one cycle of read latency
    logic [17:0] ram [logic [15:0]];

    function automatic logic [17:0] rd(input logic [15:0] a);
        return ram.exists(a) ? ram[a] : 18'd0;
    endfunction

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] = mem_wdata;
        mem_rdata <= rd(mem_addr);
    end

    function automatic logic [17:0] ones_add(input logic [17:0] a, input logic [17:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s >= 262144) s = s - 262144 + 1;
        return s[17:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model: phase 0 idle, 1 fetch, 2 decode, 3 execute, 4 memory
    int          m_phase;
    logic [15:0] m_pc;
    logic [17:0] m_acc;
    logic [17:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pc = 16'd0; m_acc = 18'd0; m_word = 18'd0;
        end else begin
            case (m_phase)
                0: if (start) m_phase = 1;
                1: m_phase = 2;
                2: begin m_word = rd(m_pc); m_pc = m_pc + 16'd1; m_phase = 3; end
                3: begin
                    case (m_word[17:16])
                        2'b00, 2'b01: m_phase = 4;
                        2'b10: begin
                            if (m_acc[17]) m_pc = m_word[15:0];
                            m_phase = 1;
                        end
                        default: if (opr_done) begin
                            m_acc = opr_acc_in;
                            m_phase = opr_halt ? 0 : 1;
                        end
                    endcase
                end
                default: begin
                    if (m_word[17:16] == 2'b01) m_acc = ones_add(m_acc, rd(m_word[15:0]));
                    m_phase = 1;
                end
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R2/R8 running", {31'd0, running}, {31'd0, m_phase != 0});
            chk("R3/R6 pc", {16'd0, pc_q}, {16'd0, m_pc});
            chk("R5/R7 acc", {14'd0, acc_q}, {14'd0, m_acc});
            chk("R4 mem_we", {31'd0, mem_we},
                {31'd0, (m_phase == 4) && (m_word[17:16] == 2'b00)});
            if (mem_we) chk("R4 wdata", {14'd0, mem_wdata}, {14'd0, m_acc});
            chk("R7 opr_req", {31'd0, opr_req},
                {31'd0, (m_phase == 3) && (m_word[17:16] == 2'b11)});
            if (opr_req) chk("R7 opr_field", {16'd0, opr_field}, {16'd0, m_word[15:0]});
            if (m_phase == 1 || m_phase == 2)
                chk("R3 fetch addr", {16'd0, mem_addr}, {16'd0, m_pc});
            if (m_phase >= 3)
                chk("R4/R5 operand addr", {16'd0, mem_addr}, {16'd0, m_word[15:0]});
        end
    end

    // operate responder: waits field[2:0] cycles, xors the field into the accumulator
    int opr_cnt = 0;
    always @(negedge clk) begin
        if (opr_done) begin
            opr_done = 1'b0; opr_halt = 1'b0; opr_cnt = 0;
        end else if (opr_req) begin
            if (opr_cnt >= int'(opr_field[2:0])) begin
                opr_done   = 1'b1;
                opr_acc_in = acc_q ^ {2'b00, opr_field};
                opr_halt   = opr_field[15];
            end else begin
                opr_cnt++;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000 && !ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0;
        opr_done = 1'b0; opr_halt = 1'b0; opr_acc_in = 18'd0;
        // program
        ram[16'h0000] = {2'b01, 16'h0100};   // add 5
        ram[16'h0001] = {2'b01, 16'h0101};   // add -2, end-around carry
        ram[16'h0002] = {2'b00, 16'h0102};   // store 3
        ram[16'h0003] = {2'b10, 16'h0010};   // branch not taken
        ram[16'h0004] = {2'b01, 16'h0103};   // add -15, negative result
        ram[16'h0005] = {2'b10, 16'h0020};   // branch taken
        ram[16'h0020] = {2'b11, 16'h0005};   // operate with waits
        ram[16'h0021] = {2'b00, 16'h0104};
        ram[16'h0022] = {2'b01, 16'h0102};
        ram[16'h0023] = {2'b11, 16'h8000};   // halting operate
        ram[16'h0024] = {2'b01, 16'h0105};   // add negative zero
        ram[16'h0025] = {2'b10, 16'hFFFF};   // branch to top of memory
        ram[16'hFFFF] = {2'b11, 16'h8000};   // halt, PC wraps
        ram[16'h0100] = 18'd5;
        ram[16'h0101] = 18'h3FFFD;
        ram[16'h0103] = 18'h3FFF0;
        ram[16'h0105] = 18'h3FFFF;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 running", {31'd0, running}, 32'd0);
        chk("R1 pc", {16'd0, pc_q}, 32'd0);
        chk("R1 acc", {14'd0, acc_q}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        chk("R1 opr_req", {31'd0, opr_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // R2 ignored while running
        while (running) @(negedge clk);
        // R8 halted after the first operate halt
        chk("R8 pc after halt", {16'd0, pc_q}, 32'h0024);
        chk("R8 acc after halt", {14'd0, acc_q}, 32'h37FF9);
        repeat (5) @(negedge clk);
        chk("R8 still idle", {31'd0, running}, 32'd0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (running) @(negedge clk);
        chk("R3 pc wrapped", {16'd0, pc_q}, 32'h0000);
        chk("R5/R7 final acc", {14'd0, acc_q}, 32'h3FFF9);
        chk("R4 stored word 0x102", {14'd0, rd(16'h0102)}, 32'h00003);
        chk("R4 stored word 0x104", {14'd0, rd(16'h0104)}, 32'h3FFF6);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule